// File: doc/BRIEF.md
# Priority-Ordered Insertion Queue

This block is one physical queue of cells, each carrying a small priority value and a data word. The cell at the head is always the next to leave. A new cell is not appended at the tail. It is written into the array at the place its priority sets: after every stored cell of the same or a more urgent priority, and before every stored cell of a less urgent one. Seen from outside, the queue acts like a group of per-priority FIFOs served most urgent first. Only one ordered shift-register array holds the cells.

Each storage slot is a register stage. In a cycle, each slot either holds its cell, takes the cell from the slot above, takes the cell from the slot below, or loads the incoming cell. A count of queued cells whose priority is not less urgent than the incoming one sets the insert position. A pop and a push in the same cycle both take effect. The head is removed first and the insert position is computed on what remains.

Top module: `pifo_queue`

## Requirements
- R1: After the asynchronous active-low reset, empty_o is 1, full_o is 0 and overflow_o is 0.
- R2: The priority field is PRIO_W bits wide (2 by default). Value 0 is the most urgent, and a smaller value always departs before a larger value.
- R3: Cells of equal priority depart in the order they were pushed.
- R4: A pushed cell is placed after every queued cell whose priority value is less than or equal to its own, and ahead of every queued cell with a greater value.
- R5: head_data_o and head_prio_o always show the cell at the head. A pop on a non-empty queue removes that cell at the clock edge. A pop while empty is ignored.
- R6: full_o is 1 when DEPTH cells (16 by default) are stored. empty_o is 1 when none are stored.
- R7: A push while full with no pop is dropped, and the contents stay unchanged. overflow_o is 1 in that same cycle only.
- R8: A push and a pop in the same cycle are both honored, also when the queue is full. The head is removed before the insert position is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Insert a cell this cycle |
| push_prio_i | input | PRIO_W | Priority of the pushed cell, 0 most urgent |
| push_data_i | input | DATA_W | Data of the pushed cell |
| pop_i | input | 1 | Remove the head cell this cycle |
| head_data_o | output | DATA_W | Data of the head cell |
| head_prio_o | output | PRIO_W | Priority of the head cell |
| empty_o | output | 1 | No cell stored |
| full_o | output | 1 | DEPTH cells stored |
| overflow_o | output | 1 | Push dropped this cycle because the queue is full |

## Verification
Each push or pop changes the head, the flags and the order of the stored cells at the next rising edge. The bench drives inputs at the falling edge and compares head and flags against a reference queue at the following falling edge, once the edge between them has updated the reference. overflow_o is combinational, so it is checked one time step after the inputs are driven, before that edge. Order checks come from popping every remaining cell and comparing each head against the front of the reference queue, which keeps its entries in the order R4 defines.

// File: rtl/pifo_pkg.sv
package pifo_pkg;
  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_UP   = 2'd1,
    SEL_DOWN = 2'd2,
    SEL_NEW  = 2'd3
  } slot_sel_e;
endpackage

// File: rtl/pifo_slot.sv
module pifo_slot
  import pifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRIO_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_sel_e         sel_i,
  input  logic              up_vld_i,
  input  logic [PRIO_W-1:0] up_prio_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              dn_vld_i,
  input  logic [PRIO_W-1:0] dn_prio_i,
  input  logic [DATA_W-1:0] dn_data_i,
  input  logic [PRIO_W-1:0] new_prio_i,
  input  logic [DATA_W-1:0] new_data_i,
  output logic              vld_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      prio_o <= '0;
      data_o <= '0;
    end else begin
      unique case (sel_i)
        SEL_UP: begin
          vld_o  <= up_vld_i;
          prio_o <= up_prio_i;
          data_o <= up_data_i;
        end
        SEL_DOWN: begin
          vld_o  <= dn_vld_i;
          prio_o <= dn_prio_i;
          data_o <= dn_data_i;
        end
        SEL_NEW: begin
          vld_o  <= 1'b1;
          prio_o <= new_prio_i;
          data_o <= new_data_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pifo_insert_pos.sv
module pifo_insert_pos #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              vld_i  [DEPTH],
  input  logic [PRIO_W-1:0] prio_i [DEPTH],
  input  logic [PRIO_W-1:0] new_prio_i,
  input  logic              drop_head_i,
  output logic [CNT_W-1:0]  pos_o
);
  logic [CNT_W-1:0] ahead;

  always_comb begin
    ahead = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_i[i] && (prio_i[i] <= new_prio_i)) ahead = ahead + CNT_W'(1);
    end
  end

  // head leaving this cycle no longer counts as ahead of the new cell
  always_comb begin
    pos_o = ahead;
    if (drop_head_i && vld_i[0] && (prio_i[0] <= new_prio_i)) pos_o = ahead - CNT_W'(1);
  end
endmodule

// File: rtl/pifo_queue.sv
module pifo_queue
  import pifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int PRIO_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic [PRIO_W-1:0] head_prio_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              vld  [DEPTH];
  logic [PRIO_W-1:0] prio [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];

  logic             do_pop, do_ins;
  logic [CNT_W-1:0] ins_pos;

  assign empty_o     = ~vld[0];
  assign full_o      = vld[DEPTH-1];
  assign head_data_o = data[0];
  assign head_prio_o = prio[0];

  assign do_pop     = pop_i & vld[0];
  assign do_ins     = push_i & (~full_o | do_pop);
  assign overflow_o = push_i & ~do_ins;

  pifo_insert_pos #(
    .DEPTH (DEPTH),
    .PRIO_W(PRIO_W)
  ) u_pos (
    .vld_i      (vld),
    .prio_i     (prio),
    .new_prio_i (push_prio_i),
    .drop_head_i(do_pop),
    .pos_o      (ins_pos)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_sel_e         sel;
    logic              up_vld, dn_vld;
    logic [PRIO_W-1:0] up_prio, dn_prio;
    logic [DATA_W-1:0] up_data, dn_data;

    if (i == DEPTH - 1) begin : g_top
      assign up_vld  = 1'b0;
      assign up_prio = '0;
      assign up_data = '0;
    end else begin : g_mid
      assign up_vld  = vld[i+1];
      assign up_prio = prio[i+1];
      assign up_data = data[i+1];
    end

    if (i == 0) begin : g_bot
      assign dn_vld  = 1'b0;
      assign dn_prio = '0;
      assign dn_data = '0;
    end else begin : g_low
      assign dn_vld  = vld[i-1];
      assign dn_prio = prio[i-1];
      assign dn_data = data[i-1];
    end

    always_comb begin
      if (!do_ins) begin
        sel = do_pop ? SEL_UP : SEL_HOLD;
      end else if (CNT_W'(i) < ins_pos) begin
        sel = do_pop ? SEL_UP : SEL_HOLD;
      end else if (CNT_W'(i) == ins_pos) begin
        sel = SEL_NEW;
      end else begin
        sel = do_pop ? SEL_HOLD : SEL_DOWN;
      end
    end

    pifo_slot #(
      .DATA_W(DATA_W),
      .PRIO_W(PRIO_W)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (sel),
      .up_vld_i  (up_vld),
      .up_prio_i (up_prio),
      .up_data_i (up_data),
      .dn_vld_i  (dn_vld),
      .dn_prio_i (dn_prio),
      .dn_data_i (dn_data),
      .new_prio_i(push_prio_i),
      .new_data_i(push_data_i),
      .vld_o     (vld[i]),
      .prio_o    (prio[i]),
      .data_o    (data[i])
    );

    if (i < DEPTH - 1) begin : g_chk
      assert_contiguous_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld[i+1] |-> vld[i]);
      assert_sorted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld[i+1] |-> (prio[i] <= prio[i+1]));
    end
  end

  assert_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);

  assert_first_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && empty_o) |=> (!empty_o && head_prio_o == $past(push_prio_i)
                             && head_data_o == $past(push_data_i)));

  assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> (full_o && $stable(head_data_o) && $stable(head_prio_o)));

  assert_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && vld[1]) |=> (head_data_o == $past(data[1])));

  assert_swap_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full_o) |=> full_o);
endmodule

// File: tb/tb_pifo_queue.sv
module tb_pifo_queue;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 16;
  localparam int PRIO_W = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              push_i = 1'b0;
  logic [PRIO_W-1:0] push_prio_i = '0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic              pop_i = 1'b0;
  logic [DATA_W-1:0] head_data_o;
  logic [PRIO_W-1:0] head_prio_o;
  logic              empty_o, full_o, overflow_o;

  typedef struct packed {
    logic [PRIO_W-1:0] p;
    logic [DATA_W-1:0] d;
  } cell_t;

  cell_t mq[$];
  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  logic [DATA_W-1:0] seq = 16'h0100;

  always #4 clk_i = ~clk_i;

  pifo_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) dut (
    .clk_i, .rst_ni, .push_i, .push_prio_i, .push_data_i, .pop_i,
    .head_data_o, .head_prio_o, .empty_o, .full_o, .overflow_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare head and flags against the scoreboard state
  task automatic observe(string req);
    chk({req, " empty"}, 32'(empty_o), 32'(mq.size() == 0));
    chk({req, " full"}, 32'(full_o), 32'(mq.size() == DEPTH));
    if (mq.size() != 0) begin
      chk({req, " head_prio"}, 32'(head_prio_o), 32'(mq[0].p));
      chk({req, " head_data"}, 32'(head_data_o), 32'(mq[0].d));
    end
  endtask

  // driver: one cycle of stimulus; scoreboard updated to post-edge state
  task automatic cyc(bit psh, logic [PRIO_W-1:0] pr, bit pp, string req);
    bit pop_eff, exp_ovf;
    int idx;
    cell_t c;
    @(negedge clk_i);
    observe(req);
    seq         = seq + 1;
    push_i      = psh;
    push_prio_i = pr;
    push_data_i = seq;
    pop_i       = pp;
    #1;
    pop_eff = pp && mq.size() > 0;
    exp_ovf = psh && !pop_eff && mq.size() == DEPTH;
    chk({req, " overflow R7"}, 32'(overflow_o), 32'(exp_ovf));
    if (pop_eff) void'(mq.pop_front());
    if (psh && !exp_ovf) begin
      idx = 0;
      foreach (mq[k]) if (mq[k].p <= pr) idx = k + 1;
      c.p = pr;
      c.d = seq;
      mq.insert(idx, c);
    end
  endtask

  task automatic idle(string req);
    cyc(1'b0, '0, 1'b0, req);
  endtask

  task automatic drain(string req);
    while (mq.size() > 0) cyc(1'b0, '0, 1'b1, req);
    idle(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 empty", 32'(empty_o), 32'd1);
    chk("R1 full", 32'(full_o), 32'd0);
    chk("R1 overflow", 32'(overflow_o), 32'd0);
    rst_ni = 1'b1;

    // R5: pop on empty ignored
    cyc(1'b0, '0, 1'b1, "R5 pop-empty");
    idle("R5 pop-empty");

    // R2, R4: mixed priorities reorder
    cyc(1'b1, 2'd3, 1'b0, "R4");
    cyc(1'b1, 2'd1, 1'b0, "R4");
    cyc(1'b1, 2'd2, 1'b0, "R4");
    cyc(1'b1, 2'd0, 1'b0, "R2");
    cyc(1'b1, 2'd1, 1'b0, "R4");
    drain("R2 drain");

    // R3: same priority keeps arrival order
    for (int i = 0; i < 5; i++) cyc(1'b1, 2'd2, 1'b0, "R3");
    drain("R3 drain");

    // R6, R7: fill, overflow, then full swap
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, PRIO_W'(i % 3), 1'b0, "R6 fill");
    idle("R6 full");
    cyc(1'b1, 2'd0, 1'b0, "R7 drop");
    cyc(1'b1, 2'd3, 1'b0, "R7 drop");
    idle("R7 unchanged");
    // R8: push+pop at full, new cell goes ahead of lower-urgency cells
    cyc(1'b1, 2'd0, 1'b1, "R8 full swap");
    cyc(1'b1, 2'd3, 1'b1, "R8 full swap");
    idle("R8");
    drain("R8 drain");

    // R8: single-entry push+pop, head removed before placement
    cyc(1'b1, 2'd1, 1'b0, "R8 single");
    cyc(1'b1, 2'd2, 1'b1, "R8 single");
    cyc(1'b1, 2'd1, 1'b1, "R8 single");
    drain("R8 single drain");

    // mixed random traffic
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 3) != 0, PRIO_W'($urandom), ($urandom % 2) == 1, "R4 random");
    drain("R3 random drain");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule